// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Driver

This block turns one bit of a microcontroller-style port register into the two control lines of a pad. When the bit is 0 the pad is pulled low. When the bit goes from 0 to 1, the pad gets a strong high drive for a fixed number of clocks. The strong drive is then withdrawn and an external weak pull-up keeps the line high. Because the line is then only weakly held, an outside device can still pull it low, so the pin also works as an input.

A mode input selects open-drain operation. In that mode the pad is never driven high. A 0 still pulls the line low, and a 1 leaves it to the pull-up. The port bit and the mode are sampled on the rising clock edge. The strong-high output is also masked directly by the mode input, so a strong drive already in progress stops as soon as open-drain mode is selected.

Top module: `qbd_pin_driver`

## Requirements
- R1: When `port_bit_i` is sampled as 0, `pull_down_o` is 1 and `strong_up_o` is 0 from the next cycle. A 0 that arrives during a strong-high window ends that window at the same edge.
- R2: In quasi mode (`open_drain_i` = 0), a 0-to-1 change of the sampled port bit releases `pull_down_o` and raises `strong_up_o` from the next cycle. `strong_up_o` stays high for exactly `BOOST_CYCLES` cycles.
- R3: After the strong-high window ends with the port bit held at 1, both outputs are 0, so the line is left to the weak pull-up.
- R4: A port bit that stays at 1 never starts a new window. This includes the case where the mode returns to quasi while the bit is already 1.
- R5: In open-drain mode (`open_drain_i` = 1), `strong_up_o` is never 1. A sampled 0 still sets `pull_down_o`, and a 0-to-1 change starts no window.
- R6: Raising `open_drain_i` during a strong-high window forces `strong_up_o` to 0 in that same cycle, with no clock edge needed. The window does not resume later.
- R7: `pull_down_o` and `strong_up_o` are never 1 at the same time.
- R8: Reset (`rst_ni` = 0, asynchronous) loads a port value of 1. After reset both outputs are 0, and a port bit of 1 right after reset starts no window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_bit_i | input | 1 | Port data bit from the controller core |
| open_drain_i | input | 1 | 1 selects open-drain mode, 0 selects quasi-bidirectional mode |
| pull_down_o | output | 1 | Enables the pad's low driver |
| strong_up_o | output | 1 | Enables the pad's temporary strong high driver |

## Verification
The assertions rely on `port_bit_i` and `open_drain_i` being settled at each rising edge. They also rely on `open_drain_i` not pulsing between two edges, because the combinational mask on `strong_up_o` is only observed at sampling points. The bench changes both inputs only on the falling edge and holds each value for a full cycle. It checks the outputs one time unit after the change, so it sees the effect of the immediate mask before the next edge. A checker-side counter of consecutive strong-high cycles bounds the window length without a deep `$past`.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
    typedef enum logic {
        QBD_MODE_QUASI = 1'b0,
        QBD_MODE_OPEN  = 1'b1
    } qbd_mode_e;
endpackage

// File: rtl/qbd_edge_sense.sv
module qbd_edge_sense (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic port_bit_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic level;
    } sense_st_t;

    sense_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = port_bit_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.level <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign rise_o  = port_bit_i & ~st_q.level;
endmodule

// File: rtl/qbd_boost_timer.sv
module qbd_boost_timer #(
    parameter int unsigned BOOST_CYCLES = 2,
    parameter int unsigned CNT_W        = $clog2(BOOST_CYCLES + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic clear_i,
    output logic active_o
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BOOST_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } timer_st_t;

    timer_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.remain = '0;
        end else if (start_i) begin
            st_d.remain = LOAD_VAL;
        end else if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.remain <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.remain != '0);
endmodule

// File: rtl/qbd_pad_decode.sv
module qbd_pad_decode (
    input  qbd_pkg::qbd_mode_e mode_i,
    input  logic               level_i,
    input  logic               boost_i,
    output logic               pull_down_o,
    output logic               strong_up_o
);
    always_comb begin
        pull_down_o = ~level_i;
        strong_up_o = boost_i & level_i & (mode_i == qbd_pkg::QBD_MODE_QUASI);
    end
endmodule

// File: rtl/qbd_pin_driver.sv
module qbd_pin_driver #(
    parameter int unsigned BOOST_CYCLES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic port_bit_i,
    input  logic open_drain_i,
    output logic pull_down_o,
    output logic strong_up_o
);
    localparam int unsigned CNT_W = $clog2(BOOST_CYCLES + 1);

    qbd_pkg::qbd_mode_e mode;
    logic level, rise, boost, timer_clear;

    assign mode        = qbd_pkg::qbd_mode_e'(open_drain_i);
    assign timer_clear = (mode == qbd_pkg::QBD_MODE_OPEN) | ~port_bit_i;

    qbd_edge_sense sense_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .port_bit_i (port_bit_i),
        .level_o    (level),
        .rise_o     (rise)
    );

    qbd_boost_timer #(
        .BOOST_CYCLES (BOOST_CYCLES),
        .CNT_W        (CNT_W)
    ) timer_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (rise),
        .clear_i  (timer_clear),
        .active_o (boost)
    );

    qbd_pad_decode decode_i (
        .mode_i      (mode),
        .level_i     (level),
        .boost_i     (boost),
        .pull_down_o (pull_down_o),
        .strong_up_o (strong_up_o)
    );
endmodule

// File: rtl/qbd_pin_checker.sv
module qbd_pin_checker #(
    parameter int unsigned BOOST_CYCLES = 2
) (
    input logic clk_i,
    input logic rst_ni,
    input logic port_bit_i,
    input logic open_drain_i,
    input logic pull_down_o,
    input logic strong_up_o
);
    logic [31:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (strong_up_o) begin
            run_q <= (run_q == 32'hFFFF_FFFF) ? run_q : run_q + 1;
        end else begin
            run_q <= '0;
        end
    end

    assert_low_pulls_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !port_bit_i |=> (pull_down_o && !strong_up_o));

    assert_rise_boosts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (port_bit_i && pull_down_o && !open_drain_i) |=> (strong_up_o || open_drain_i));

    assert_window_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strong_up_o |-> (run_q < BOOST_CYCLES));

    assert_window_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strong_up_o && port_bit_i && !open_drain_i && (run_q + 1 < BOOST_CYCLES))
        |=> (strong_up_o || open_drain_i));

    assert_high_releases_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        port_bit_i |=> !pull_down_o);

    assert_open_no_boost_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        open_drain_i |-> !strong_up_o);

    assert_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pull_down_o && strong_up_o));

    assert_reset_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!pull_down_o && !strong_up_o));
endmodule

bind qbd_pin_driver qbd_pin_checker #(
    .BOOST_CYCLES (BOOST_CYCLES)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .port_bit_i   (port_bit_i),
    .open_drain_i (open_drain_i),
    .pull_down_o  (pull_down_o),
    .strong_up_o  (strong_up_o)
);

// File: tb/qbd_pin_driver_tb.sv
`timescale 1ns/1ps
module qbd_pin_driver_tb_top;
    localparam int unsigned BOOST = 3;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic port_bit_i = 1'b1;
    logic open_drain_i = 1'b0;
    logic pull_down_o, strong_up_o;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 0;

    // bench-side expectation state
    bit m_level = 1'b1;
    int m_remain = 0;

    always #5 clk_i = ~clk_i;

    qbd_pin_driver #(.BOOST_CYCLES(BOOST)) dut_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .port_bit_i   (port_bit_i),
        .open_drain_i (open_drain_i),
        .pull_down_o  (pull_down_o),
        .strong_up_o  (strong_up_o)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit p, input bit od, input string tag);
        bit exp_pd, exp_su;
        @(negedge clk_i);
        port_bit_i   = p;
        open_drain_i = od;
        #1;
        exp_pd = !m_level;
        exp_su = (m_remain > 0) && m_level && !od;
        check(pull_down_o, exp_pd, tag, "pull_down_o");
        check(strong_up_o, exp_su, tag, "strong_up_o");
        check(pull_down_o && strong_up_o, 1'b0, "R7", "both enables");
        @(posedge clk_i);
        if (od || !p)            m_remain = 0;
        else if (p && !m_level)  m_remain = BOOST;
        else if (m_remain > 0)   m_remain--;
        m_level = p;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #1;
        check(pull_down_o, 1'b0, "R8", "pull_down_o in reset");
        check(strong_up_o, 1'b0, "R8", "strong_up_o in reset");
        @(negedge clk_i);
        rst_ni = 1'b1;
        // R8: port 1 after reset gives no pulse
        repeat (4) step(1, 0, "R8");
        // R1: drive low
        repeat (3) step(0, 0, "R1");
        // R2 then R3: rise, full window, then idle high
        repeat (BOOST + 1) step(1, 0, "R2");
        repeat (3) step(1, 0, "R3");
        // R4: steady high, no new pulse
        repeat (4) step(1, 0, "R4");
        // R1: low arriving mid-window
        step(0, 0, "R1");
        step(1, 0, "R2");
        step(1, 0, "R2");
        step(0, 0, "R1");
        step(0, 0, "R1");
        // R5: open-drain low and rise
        repeat (2) step(0, 1, "R5");
        repeat (4) step(1, 1, "R5");
        // R4: back to quasi while already high
        repeat (4) step(1, 0, "R4");
        // R6: open-drain in the middle of a window
        step(0, 0, "R6");
        step(1, 0, "R6");
        step(1, 0, "R6");
        step(1, 1, "R6");
        repeat (BOOST + 1) step(1, 0, "R6");
        // exhaustive sweep over all six-step sequences of the two inputs
        for (int n = 0; n < 4096; n++) begin
            for (int d = 0; d < 6; d++) begin
                int sym;
                sym = (n >> (2 * d)) & 3;
                step(sym[0], sym[1], "R2");
            end
        end
        // reset in the middle of a window, then R8 again
        step(0, 0, "R1");
        step(1, 0, "R2");
        @(negedge clk_i);
        rst_ni = 1'b0;
        m_level = 1'b1;
        m_remain = 0;
        #1;
        check(strong_up_o, 1'b0, "R8", "strong_up_o after async reset");
        check(pull_down_o, 1'b0, "R8", "pull_down_o after async reset");
        @(negedge clk_i);
        rst_ni = 1'b1;
        repeat (3) step(1, 0, "R8");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule